// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the time base that PWM compare and output logic use. A 16-bit counter advances once per prescaled tick. The prescaler divides the system clock by a power of two multiplied by an even factor. The counting pattern is chosen by a control field: saw-tooth up, saw-tooth down, triangle (up-down), or frozen. Each time the counter reaches zero or the active period, the block emits a one-cycle strobe. It also exports the live count and the travel direction to downstream compare units.

Software reaches the block through a small word-wide port: one control register and one period register. Period writes go to a shadow copy. That copy moves into the active period when the counter passes zero, or at once when the immediate-load bit is set. A stop-request input lets a debugger or a system halt freeze the time base. The run field selects whether it stops at once, stops at the end of the current cycle, or ignores the request.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter reads 0, no event strobe is high, both period copies read 0 and the control register reads 0x0003. Read address 0 returns control, 1 the active period, 2 the shadow period and 3 the counter. Write address 0 is control and write address 1 is the period.
- R2: With control bits [1:0] = 00 the counter steps 0,1,…,P and then returns to 0, where P is the active period. zero_evt pulses for one cycle with the counter at 0, and prd_evt pulses with the counter at P.
- R3: With control bits [1:0] = 01 the counter steps P, P-1, …, 0 and then reloads P.
- R4: With control bits [1:0] = 10 the counter rises to P, then falls to 0, then rises again. dir_down is 1 while it falls and 0 while it rises. Each extreme value appears once per turn.
- R5: With control bits [1:0] = 11 the counter holds its value.
- R6: The counter advances once every N clock cycles. N = 2^c × (h = 0 ? 1 : 2h), where h is control bits [9:7] and c is control bits [12:10].
- R7: A control write that changes h or c restarts the prescale count, so the next step comes a full N cycles after that write.
- R8: With control bit 3 = 0 a period write changes only the shadow period. The active period takes the shadow value in the cycle after one in which the counter is 0.
- R9: With control bit 3 = 1 a period write updates the active period in the next cycle.
- R10: With control bits [15:14] = 00 the counter holds while stop_req is high.
- R11: With control bits [15:14] = 01 and stop_req high, the counter keeps counting until it reaches 0 and then holds there.
- R12: With control bits [15:14] = 10 or 11, stop_req has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 period) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| stop_req | input | 1 | Halt request, handled per the run field |
| count | output | 16 | Current counter value |
| dir_down | output | 1 | 1 while the counter moves downward |
| zero_evt | output | 1 | One-cycle strobe: counter reached 0 |
| prd_evt | output | 1 | One-cycle strobe: counter reached the period |

## Verification
The bench lines up on the event strobes and then checks exact count sequences at each turning point. A counter off by one at the period, or one that shows an extreme value twice in triangle mode, breaks those sequences at once. The divider changes that keep the same ratio are there to catch a prescaler that is not restarted: the next step would come several cycles early. A period write in the middle of a cycle shows whether the design leaks the shadow value into the active period too early. The stop tests separate the run modes: one that halts at once, one that runs on to zero before halting, and one that ignores the request. A run-mode decode that is mixed up leaves the counter at the wrong value.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    localparam int DIV_W   = 3;
    localparam int PS_W    = (1 << DIV_W) - 1 + 1 + DIV_W;
    localparam int REG_W   = 16;

    localparam int MODE_LSB = 0;
    localparam int IMM_BIT  = 3;
    localparam int HSP_LSB  = 7;
    localparam int CKD_LSB  = 10;
    localparam int RUN_LSB  = 14;

    localparam logic [REG_W-1:0] CTRL_RST = 16'h0003;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_HOLD = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RUN_HALT_NOW = 2'b00,
        RUN_HALT_CYC = 2'b01,
        RUN_FREE_A   = 2'b10,
        RUN_FREE     = 2'b11
    } run_mode_e;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_PRD    = 2'd1,
        ADDR_SHADOW = 2'd2,
        ADDR_COUNT  = 2'd3
    } reg_addr_e;

    function automatic logic [PS_W-1:0] ps_ratio(input logic [DIV_W-1:0] hs,
                                                 input logic [DIV_W-1:0] ck);
        logic [PS_W-1:0] base;
        logic [PS_W-1:0] fac;
        base = PS_W'(1) << ck;
        fac  = (hs == '0) ? PS_W'(1) : PS_W'({hs, 1'b0});
        return PS_W'(base * fac);
    endfunction

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler
    import pwm_tb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] hsp_div,
    input  logic [DIV_W-1:0] ck_div,
    output logic             tick
);
    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } ps_state_t;

    ps_state_t       st_d, st_q;
    logic [PS_W-1:0] ratio;

    always_comb begin
        ratio = ps_ratio(hsp_div, ck_div);
        tick  = (st_q.cnt == ratio - PS_W'(1));
        st_d  = st_q;
        if (restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_ps_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < ratio);
    assert_ps_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    input  logic             imm_load,
    input  logic             cnt_at_zero,
    output logic [CNT_W-1:0] prd_active,
    output logic [CNT_W-1:0] prd_shadow
);
    typedef struct packed {
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] shd;
    } prd_state_t;

    prd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (prd_wr) begin
            st_d.shd = prd_wdata;
        end
        if (imm_load) begin
            if (prd_wr) st_d.act = prd_wdata;
        end else if (cnt_at_zero) begin
            st_d.act = st_q.shd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prd_active = st_q.act;
    assign prd_shadow = st_q.shd;

    assert_shadow_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_load && cnt_at_zero) |=> (prd_active == $past(prd_shadow)));
    assert_shadow_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_load && !cnt_at_zero) |=> $stable(prd_active));
    assert_imm_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_load && prd_wr) |=> (prd_active == $past(prd_wdata)));

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  run_mode_e        run,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             zero_evt,
    output logic             prd_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dn;
        logic             zev;
        logic             pev;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       halt;
    logic       step;

    always_comb begin
        st_d     = st_q;
        st_d.zev = 1'b0;
        st_d.pev = 1'b0;
        halt = stop_req && ((run == RUN_HALT_NOW) ||
                            ((run == RUN_HALT_CYC) && (st_q.cnt == '0)));
        step = tick && (mode != MODE_HOLD) && !halt;

        case (mode)
            MODE_UP:   st_d.dn = 1'b0;
            MODE_DOWN: st_d.dn = 1'b1;
            default:   ;
        endcase

        if (step) begin
            case (mode)
                MODE_UP: begin
                    st_d.cnt = (st_q.cnt >= prd) ? '0 : st_q.cnt + ONE;
                end
                MODE_DOWN: begin
                    st_d.cnt = (st_q.cnt == '0) ? prd : st_q.cnt - ONE;
                end
                MODE_UPDN: begin
                    if (!st_q.dn) begin
                        if (st_q.cnt >= prd) begin
                            st_d.dn  = 1'b1;
                            st_d.cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - ONE;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            st_d.dn  = 1'b0;
                            st_d.cnt = (prd == '0) ? '0 : ONE;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                        end
                    end
                end
                default: ;
            endcase
            st_d.zev = (st_d.cnt == '0);
            st_d.pev = (st_d.cnt == prd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = st_q.cnt;
    assign dir_down = st_q.dn;
    assign zero_evt = st_q.zev;
    assign prd_evt  = st_q.pev;

    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_UP && count == prd) |=> (count == '0));
    assert_down_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_DOWN && count == '0) |=> (count == $past(prd)));
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(count));
    assert_halt_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run == RUN_HALT_NOW && stop_req) |=> $stable(count));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             stop_req,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             zero_evt,
    output logic             prd_evt
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             ctrl_wr;
    logic             prd_wr;
    logic             div_restart;
    logic             tick;
    logic [CNT_W-1:0] prd_active;
    logic [CNT_W-1:0] prd_shadow;
    logic [CNT_W-1:0] cnt_w;

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
        prd_wr  = wr_en && (wr_addr == ADDR_PRD);
        div_restart = ctrl_wr &&
            ((wr_data[HSP_LSB +: DIV_W] != st_q.ctrl[HSP_LSB +: DIV_W]) ||
             (wr_data[CKD_LSB +: DIV_W] != st_q.ctrl[CKD_LSB +: DIV_W]));
        st_d = st_q;
        if (ctrl_wr) st_d.ctrl = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctrl: CTRL_RST};
        else        st_q <= st_d;
    end

    pwm_tb_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (div_restart),
        .hsp_div (st_q.ctrl[HSP_LSB +: DIV_W]),
        .ck_div  (st_q.ctrl[CKD_LSB +: DIV_W]),
        .tick    (tick)
    );

    pwm_tb_period #(.CNT_W(CNT_W)) u_period (
        .clk         (clk),
        .rst_n       (rst_n),
        .prd_wr      (prd_wr),
        .prd_wdata   (wr_data[CNT_W-1:0]),
        .imm_load    (st_q.ctrl[IMM_BIT]),
        .cnt_at_zero (cnt_w == '0),
        .prd_active  (prd_active),
        .prd_shadow  (prd_shadow)
    );

    pwm_tb_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (cnt_mode_e'(st_q.ctrl[MODE_LSB +: 2])),
        .run      (run_mode_e'(st_q.ctrl[RUN_LSB +: 2])),
        .stop_req (stop_req),
        .prd      (prd_active),
        .count    (cnt_w),
        .dir_down (dir_down),
        .zero_evt (zero_evt),
        .prd_evt  (prd_evt)
    );

    assign count = cnt_w;

    always_comb begin
        case (rd_addr)
            ADDR_CTRL:   rd_data = st_q.ctrl;
            ADDR_PRD:    rd_data = REG_W'(prd_active);
            ADDR_SHADOW: rd_data = REG_W'(prd_shadow);
            default:     rd_data = REG_W'(cnt_w);
        endcase
    end

    assert_free_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.ctrl[RUN_LSB+1] && st_q.ctrl[1:0] == 2'b00 && prd_active != '0)
        |=> !$stable(count));

endmodule

// File: tb/pwm_timebase_tb_top.sv
module pwm_timebase_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        stop_req = 1'b0;
    logic [15:0] count;
    logic        dir_down;
    logic        zero_evt;
    logic        prd_evt;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pwm_timebase dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .stop_req(stop_req), .count(count), .dir_down(dir_down),
        .zero_evt(zero_evt), .prd_evt(prd_evt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_zero();
        int n = 0;
        @(negedge clk);
        while (!zero_evt && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_prd();
        int n = 0;
        @(negedge clk);
        while (!prd_evt && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 count", count, 0);
        chk("R1 events", {zero_evt, prd_evt}, 0);
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0003);
        rd(2'd1, v); chk("R1 active prd", v, 0);
        rd(2'd2, v); chk("R1 shadow prd", v, 0);
    endtask

    task automatic t_up();
        wr(2'd1, 16'd4);
        wr(2'd0, 16'hC000);
        wait_zero();
        chk("R2 zero at 0", count, 0);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            chk("R2 up step", count, i);
        end
        chk("R2 prd_evt", prd_evt, 1);
        @(negedge clk);
        chk("R2 wrap", count, 0);
        chk("R2 zero_evt", zero_evt, 1);
        @(negedge clk);
        chk("R2 zero one cycle", zero_evt, 0);
    endtask

    task automatic t_down();
        wr(2'd0, 16'hC001);
        wait_prd();
        chk("R3 at period", count, 4);
        for (int i = 3; i >= 0; i--) begin
            @(negedge clk);
            chk("R3 down step", count, i);
        end
        @(negedge clk);
        chk("R3 reload", count, 4);
    endtask

    task automatic t_updn();
        logic [15:0] ec [8] = '{1, 2, 3, 4, 3, 2, 1, 0};
        logic        ed [8] = '{0, 0, 0, 0, 1, 1, 1, 1};
        wr(2'd0, 16'hC002);
        wait_zero();
        wait_zero();
        chk("R4 zero", count, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R4 tri count", count, ec[i]);
            chk("R4 dir_down", dir_down, ed[i]);
        end
    endtask

    task automatic t_hold();
        logic [15:0] c0;
        wr(2'd0, 16'hC003);
        c0 = count;
        repeat (10) @(negedge clk);
        chk("R5 frozen", count, c0);
    endtask

    task automatic t_presc();
        wr(2'd0, 16'hC480);
        wait_zero();
        repeat (3) @(negedge clk);
        chk("R6 N=4 still 0", count, 0);
        @(negedge clk);
        chk("R6 N=4 step", count, 1);
        wr(2'd0, 16'hC180);
        wait_zero();
        repeat (5) @(negedge clk);
        chk("R6 N=6 still 0", count, 0);
        @(negedge clk);
        chk("R6 N=6 step", count, 1);
    endtask

    task automatic t_restart();
        wr(2'd0, 16'hCC00);
        wait_zero();
        repeat (5) @(negedge clk);
        wr(2'd0, 16'hC880);
        repeat (7) @(negedge clk);
        chk("R7 no early step", count, 0);
        @(negedge clk);
        chk("R7 step after full N", count, 1);
    endtask

    task automatic t_shadow();
        logic [15:0] v;
        wr(2'd0, 16'hC000);
        wait_zero();
        @(negedge clk);
        wr(2'd1, 16'd9);
        rd(2'd1, v); chk("R8 active unchanged", v, 4);
        rd(2'd2, v); chk("R8 shadow written", v, 9);
        wait_zero();
        @(negedge clk);
        rd(2'd1, v); chk("R8 loaded at zero", v, 9);
        wait_prd();
        chk("R8 new period used", count, 9);
        wr(2'd0, 16'hC008);
        wr(2'd1, 16'd6);
        rd(2'd1, v); chk("R9 immediate load", v, 6);
    endtask

    task automatic t_run();
        wr(2'd0, 16'h0000);
        wait_zero();
        repeat (3) @(negedge clk);
        stop_req = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 halted at once", count, 3);
        wr(2'd0, 16'h4000);
        repeat (15) @(negedge clk);
        chk("R11 ran to zero", count, 0);
        repeat (3) @(negedge clk);
        chk("R11 held at zero", count, 0);
        wr(2'd0, 16'hC000);
        repeat (3) @(negedge clk);
        chk("R12 request ignored", count, 3);
        stop_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up();
        t_down();
        t_updn();
        t_hold();
        t_presc();
        t_restart();
        t_shadow();
        t_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule